// File: doc/BRIEF.md
# Multi-bank programmable clock divider

This block turns one fast source clock into four slower clocks: three output banks (A, B and C) and a feedback clock for an external phase-locked loop. A shared prescale stage first divides the source by 2 or 4. Each bank and the feedback path then divide the prescaled rate by a small even ratio that a select input picks. Banks A and B offer /2 or /4, bank C offers /4 or /6, and the feedback path offers /4, /6, /8 or /12. The source is expected to run in the 200 to 500 MHz range. The block itself holds no analog parts, so it is also valid when the source is a reference clock routed around the loop.

All dividers leave reset on the same source edge. Every output therefore rises on a common grid and keeps a 50% duty cycle, including the /6 and /12 ratios. The mixes 1:1, 2:1, 3:1, 3:2 and 3:2:1 between banks all stay phase-aligned. Each bank has a stop request that parks its clock low. The request is only taken while the clock is low, so no shortened pulse ever leaves the block. The bank's divider keeps counting while the bank is stopped, and a released bank rejoins the original edge grid. The active-low master reset doubles as output enable: while it is low every output is held low. The selects are meant to be static while the block runs; a change only keeps its alignment guarantee once a reset has followed it.

Top module: `clkdiv_top`

## Requirements
- R1: While mr_oe_n_i is low, all four clock outputs are low and every divider is held at its start state.
- R2: pre_sel_i picks the prescale ratio P, where 0 selects 2 and 1 selects 4 source cycles per prescaled period.
- R3: a_sel_i picks bank A's ratio NA, where 0 selects 2 and 1 selects 4, giving an output period of NA*P source cycles.
- R4: b_sel_i picks bank B's ratio NB, where 0 selects 2 and 1 selects 4, giving an output period of NB*P source cycles.
- R5: c_sel_i picks bank C's ratio NC, where 0 selects 4 and 1 selects 6, giving an output period of NC*P source cycles.
- R6: fb_sel_i picks the feedback ratio NF, where 00 selects 4, 01 selects 6, 10 selects 8 and 11 selects 12, giving an output period of NF*P source cycles.
- R7: Every output is high for exactly N*P/2 source cycles and low for N*P/2 source cycles, where N is that output's ratio.
- R8: Counting k as the number of rising source edges since mr_oe_n_i went high, an output with ratio N is high after edge k exactly when k >= P and floor((k-P)/(P*N/2)) is even. This places every output's first rising edge on the same source edge.
- R9: A stop request is sampled only while the bank's next level is low. A pulse already in progress completes at full length, and a stopped bank stays low.
- R10: Removing a stop request takes effect during a low phase, and the bank's next pulse starts on the grid of R8, as if it had never stopped.
- R11: A stop request affects only its own bank; the other banks and the feedback clock, which has no stop, keep the pattern of R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src_i | input | 1 | High-rate source clock |
| mr_oe_n_i | input | 1 | Active-low master reset and output enable, asynchronous assert |
| pre_sel_i | input | 1 | Prescale select (0: /2, 1: /4) |
| a_sel_i | input | 1 | Bank A ratio select (0: /2, 1: /4) |
| b_sel_i | input | 1 | Bank B ratio select (0: /2, 1: /4) |
| c_sel_i | input | 1 | Bank C ratio select (0: /4, 1: /6) |
| fb_sel_i | input | 2 | Feedback ratio select (00: /4, 01: /6, 10: /8, 11: /12) |
| stop_a_i | input | 1 | Stop request for bank A |
| stop_b_i | input | 1 | Stop request for bank B |
| stop_c_i | input | 1 | Stop request for bank C |
| clk_a_o | output | 1 | Bank A clock |
| clk_b_o | output | 1 | Bank B clock |
| clk_c_o | output | 1 | Bank C clock |
| clk_fb_o | output | 1 | Feedback clock |

## Verification
The bench builds the block with its default ratio parameters: prescale 2/4, banks A and B 2/4, bank C 4/6, and feedback 4/6/8/12. The longest common period is therefore 24 prescaled periods, or 96 source cycles. Each configuration is observed for more than that span, so a wrong divisor, a lost duty-cycle half or a drifted edge shows up against the closed-form edge formula. The stop test uses bank C at /6 with prescale 2. Its 6-cycle high phase leaves room to raise the request mid-pulse and to drop it mid-slot, which reaches both the no-runt case and the resume-on-grid case.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Width of a half-period counter; ratios up to 2*(2**HALF_W-1) fit.
    localparam int HALF_W = 4;

    typedef struct packed {
        logic [HALF_W-1:0] hc;    // ticks spent in the current half period
        logic              lv;    // free-running divided level
        logic              gate;  // stop latched for this bank
        logic              out;   // registered, gated output
    } lane_state_t;

endpackage

// File: rtl/clkdiv_prescale.sv
module clkdiv_prescale #(
    parameter int PRE_LO = 2,
    parameter int PRE_HI = 4
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic sel_i,
    output logic tick_o
);
    localparam int PW = (PRE_HI > 2) ? $clog2(PRE_HI) : 1;
    localparam logic [PW-1:0] LIM_LO = PW'(PRE_LO - 1);
    localparam logic [PW-1:0] LIM_HI = PW'(PRE_HI - 1);

    typedef struct packed {
        logic [PW-1:0] pc;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [PW-1:0] lim;

    always_comb begin
        lim    = sel_i ? LIM_HI : LIM_LO;
        tick_o = (s_q.pc >= lim);
        s_d    = s_q;
        if (tick_o) s_d.pc = '0;
        else        s_d.pc = s_q.pc + PW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) s_q <= '0;
        else          s_q <= s_d;
    end

    // With a prescale of at least 2, two ticks are never adjacent.
    assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        tick_o |=> !tick_o);

endmodule

// File: rtl/clkdiv_lane.sv
module clkdiv_lane
    import clkdiv_pkg::*;
#(
    parameter bit HAS_STOP = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              tick_i,
    input  logic [HALF_W-1:0] half_i,
    input  logic              stop_i,
    output logic              clk_o
);
    lane_state_t s_d, s_q;
    logic        wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.hc >= (half_i - HALF_W'(1)));
        if (tick_i) begin
            if (wrap) begin
                s_d.hc = '0;
                s_d.lv = ~s_q.lv;
            end else begin
                s_d.hc = s_q.hc + HALF_W'(1);
            end
        end
        if (HAS_STOP) begin
            // The stop request is only taken while the next level is low.
            s_d.gate = s_d.lv ? s_q.gate : stop_i;
        end else begin
            s_d.gate = 1'b0;
        end
        s_d.out = s_d.lv & ~s_d.gate;
    end

    // The counter resets to all ones so that the first tick flips the level high.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            s_q.hc   <= '1;
            s_q.lv   <= 1'b0;
            s_q.gate <= 1'b0;
            s_q.out  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign clk_o = s_q.out;

    assert_level_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !$stable(s_q.lv) |-> $past(tick_i));

    assert_gate_moves_low_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !$stable(s_q.gate) |-> !s_q.out);

    assert_stopped_low_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        s_q.gate |-> !clk_o);

    assert_rise_on_grid_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(clk_o) |-> $rose(s_q.lv));

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
    import clkdiv_pkg::*;
#(
    parameter int PRE_LO  = 2,
    parameter int PRE_HI  = 4,
    parameter int DIV_A0  = 2,
    parameter int DIV_A1  = 4,
    parameter int DIV_B0  = 2,
    parameter int DIV_B1  = 4,
    parameter int DIV_C0  = 4,
    parameter int DIV_C1  = 6,
    parameter int DIV_F0  = 4,
    parameter int DIV_F1  = 6,
    parameter int DIV_F2  = 8,
    parameter int DIV_F3  = 12
) (
    input  logic       clk_src_i,
    input  logic       mr_oe_n_i,
    input  logic       pre_sel_i,
    input  logic       a_sel_i,
    input  logic       b_sel_i,
    input  logic       c_sel_i,
    input  logic [1:0] fb_sel_i,
    input  logic       stop_a_i,
    input  logic       stop_b_i,
    input  logic       stop_c_i,
    output logic       clk_a_o,
    output logic       clk_b_o,
    output logic       clk_c_o,
    output logic       clk_fb_o
);
    localparam int NUM_LANES = 4;
    localparam int NUM_BANKS = 3;

    localparam logic [HALF_W-1:0] HA0 = HALF_W'(DIV_A0 / 2);
    localparam logic [HALF_W-1:0] HA1 = HALF_W'(DIV_A1 / 2);
    localparam logic [HALF_W-1:0] HB0 = HALF_W'(DIV_B0 / 2);
    localparam logic [HALF_W-1:0] HB1 = HALF_W'(DIV_B1 / 2);
    localparam logic [HALF_W-1:0] HC0 = HALF_W'(DIV_C0 / 2);
    localparam logic [HALF_W-1:0] HC1 = HALF_W'(DIV_C1 / 2);
    localparam logic [HALF_W-1:0] HF0 = HALF_W'(DIV_F0 / 2);
    localparam logic [HALF_W-1:0] HF1 = HALF_W'(DIV_F1 / 2);
    localparam logic [HALF_W-1:0] HF2 = HALF_W'(DIV_F2 / 2);
    localparam logic [HALF_W-1:0] HF3 = HALF_W'(DIV_F3 / 2);

    logic                              tick;
    logic [NUM_LANES-1:0][HALF_W-1:0]  half;
    logic [NUM_LANES-1:0]              stop;
    logic [NUM_LANES-1:0]              lane_clk;

    always_comb begin
        half[0] = a_sel_i ? HA1 : HA0;
        half[1] = b_sel_i ? HB1 : HB0;
        half[2] = c_sel_i ? HC1 : HC0;
        unique case (fb_sel_i)
            2'b00:   half[3] = HF0;
            2'b01:   half[3] = HF1;
            2'b10:   half[3] = HF2;
            default: half[3] = HF3;
        endcase
        stop = {1'b0, stop_c_i, stop_b_i, stop_a_i};
    end

    clkdiv_prescale #(
        .PRE_LO (PRE_LO),
        .PRE_HI (PRE_HI)
    ) i_prescale (
        .clk_i   (clk_src_i),
        .rst_n_i (mr_oe_n_i),
        .sel_i   (pre_sel_i),
        .tick_o  (tick)
    );

    // Banks carry a stop gate; the feedback lane is built without one.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        clkdiv_lane #(
            .HAS_STOP (g < NUM_BANKS)
        ) i_lane (
            .clk_i   (clk_src_i),
            .rst_n_i (mr_oe_n_i),
            .tick_i  (tick),
            .half_i  (half[g]),
            .stop_i  (stop[g]),
            .clk_o   (lane_clk[g])
        );
    end

    assign clk_a_o  = lane_clk[0];
    assign clk_b_o  = lane_clk[1];
    assign clk_c_o  = lane_clk[2];
    assign clk_fb_o = lane_clk[3];

    always @(posedge clk_src_i) begin
        if (!mr_oe_n_i) begin
            assert_reset_low_R1: assert (lane_clk == '0);
        end
    end

    // The feedback lane has no stop, so it only rises when its level does.
    assert_fb_after_tick_R11: assert property (@(posedge clk_src_i) disable iff (!mr_oe_n_i)
        $rose(clk_fb_o) |-> $past(tick));

endmodule

// File: tb/test_clkdiv_top.sv
module test_clkdiv_top;

    typedef struct packed {
        logic       pre;
        logic       a;
        logic       b;
        logic       c;
        logic [1:0] fb;
        int         p;
        int         na;
        int         nb;
        int         nc;
        int         nf;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2, 2, 2, 4, 4},
        '{1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 4, 4, 4, 6, 6},
        '{1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 2, 2, 4, 6, 8},
        '{1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 4, 4, 2, 4, 12},
        '{1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 2, 4, 4, 4, 12},
        '{1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 4, 2, 2, 6, 8}
    };
    localparam int RUN_LEN = 200;

    logic       clk = 1'b0;
    logic       mr_oe_n = 1'b0;
    logic       pre_sel = 1'b0, a_sel = 1'b0, b_sel = 1'b0, c_sel = 1'b0;
    logic [1:0] fb_sel = 2'b00;
    logic       stop_a = 1'b0, stop_b = 1'b0, stop_c = 1'b0;
    logic       clk_a, clk_b, clk_c, clk_fb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clkdiv_top i_clkdiv_top (
        .clk_src_i (clk),
        .mr_oe_n_i (mr_oe_n),
        .pre_sel_i (pre_sel),
        .a_sel_i   (a_sel),
        .b_sel_i   (b_sel),
        .c_sel_i   (c_sel),
        .fb_sel_i  (fb_sel),
        .stop_a_i  (stop_a),
        .stop_b_i  (stop_b),
        .stop_c_i  (stop_c),
        .clk_a_o   (clk_a),
        .clk_b_o   (clk_b),
        .clk_c_o   (clk_c),
        .clk_fb_o  (clk_fb)
    );

    // Expected level after source edge k (R8).
    function automatic bit model(int k, int p, int n);
        if (k < p) return 1'b0;
        return (((k - p) / ((n / 2) * p)) % 2) == 0;
    endfunction

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic restart();
        @(negedge clk);
        mr_oe_n = 1'b0;
        repeat (3) @(negedge clk);
        mr_oe_n = 1'b1;
    endtask

    task automatic run_vec(vec_t v);
        int bad_a = 0, bad_b = 0, bad_c = 0, bad_f = 0;
        pre_sel = v.pre; a_sel = v.a; b_sel = v.b; c_sel = v.c; fb_sel = v.fb;
        restart();
        for (int k = 1; k <= RUN_LEN; k++) begin
            @(negedge clk);
            if (clk_a  != model(k, v.p, v.na)) bad_a++;
            if (clk_b  != model(k, v.p, v.nb)) bad_b++;
            if (clk_c  != model(k, v.p, v.nc)) bad_c++;
            if (clk_fb != model(k, v.p, v.nf)) bad_f++;
        end
        check("R3 R2 R7 R8 bank A mismatched cycles", bad_a, 0);
        check("R4 R2 R7 R8 bank B mismatched cycles", bad_b, 0);
        check("R5 R2 R7 R8 bank C mismatched cycles", bad_c, 0);
        check("R6 R2 R7 R8 feedback mismatched cycles", bad_f, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs low while held in reset
        repeat (4) @(negedge clk);
        check("R1 outputs in reset", {clk_a, clk_b, clk_c, clk_fb}, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1: reset asserted during a high phase forces all outputs low
        pre_sel = 1'b0; a_sel = 1'b0; b_sel = 1'b0; c_sel = 1'b0; fb_sel = 2'b00;
        restart();
        repeat (2) @(negedge clk);
        check("R1 all high before mid-run reset", {clk_a, clk_b, clk_c, clk_fb}, 4'hF);
        mr_oe_n = 1'b0;
        #1;
        check("R1 mid-run reset", {clk_a, clk_b, clk_c, clk_fb}, 0);

        // Stop test on bank C at /6 with prescale 2: high for k in [2,8), [14,20), [26,32)
        begin
            int run = 0, short_runs = 0, extra = 0, bad_other = 0;
            pre_sel = 1'b0; a_sel = 1'b0; b_sel = 1'b1; c_sel = 1'b1; fb_sel = 2'b10;
            restart();
            for (int k = 1; k <= 60; k++) begin
                @(negedge clk);
                if (k == 4)  stop_c = 1'b1;
                if (k == 17) stop_c = 1'b0;
                if (k == 7)  check("R9 pulse in progress completes", clk_c, 1);
                if (k == 14) check("R9 stopped bank low", clk_c, 0);
                if (k == 19) check("R10 release waits for low phase", clk_c, 0);
                if (k == 26) check("R10 resumed on grid", clk_c, 1);
                if (clk_c && !model(k, 2, 6)) extra++;
                if (clk_c) run++;
                else begin
                    if (run != 0 && run != 6) short_runs++;
                    run = 0;
                end
                if (clk_a != model(k, 2, 2) || clk_b != model(k, 2, 4) ||
                    clk_fb != model(k, 2, 8)) bad_other++;
            end
            check("R9 runt pulses on bank C", short_runs, 0);
            check("R10 bank C high off grid", extra, 0);
            check("R11 other outputs disturbed by stop", bad_other, 0);
        end

        // R11: stopping bank A leaves bank B and C untouched, A stays low
        begin
            int bad = 0, a_high = 0;
            restart();
            stop_a = 1'b1;
            for (int k = 1; k <= 40; k++) begin
                @(negedge clk);
                if (clk_a) a_high++;
                if (clk_b != model(k, 2, 4) || clk_c != model(k, 2, 6)) bad++;
            end
            stop_a = 1'b0;
            check("R9 bank A stopped from reset", a_high, 0);
            check("R11 banks B and C with A stopped", bad, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule